// File: doc/BRIEF.md
# Remote Register Write Bridge

This block sits between a local host and a side link that reaches a remote device. The host fills a sixteen-entry staging buffer, picks the target device ID, a byte count and the first remote register address over a plain synchronous register bus, and then sets a start bit. The bridge walks the staged bytes out as one link transaction per byte. Each transaction carries the device ID, a remote register address that rises by one per byte, and the data byte. The bridge waits for the link to acknowledge each one before it moves on.

When the last byte has been acknowledged, the bridge sets a sticky completion flag and pulls its interrupt line low. Any host write to the status register lowers the flag and releases the interrupt. A mode field selects how the start access is handled. In hold mode the host bus reports not-ready until the burst has finished, which stands in for bus clock stretching. In free mode the bus stays ready and the host waits for the interrupt instead.

The remote register window ends at 0xFF. A burst that would run past it is cut short at 0xFF and does not wrap.

Top module: `remote_wr_bridge`

## Requirements
- R1: Host addresses 0x10 to 0x1F are a read/write staging buffer. Entry k sits at 0x10+k, and entry 0 is the first byte sent.
- R2: Register 0x20 holds the 7-bit device ID, which resets to 0x0B. Every link transaction of a burst carries the ID that was latched at start.
- R3: Register 0x21 holds a 4-bit count C. A burst sends C+1 bytes unless R6 shortens it.
- R4: Register 0x23 holds the first remote address A. Byte k of a burst goes to address A+k with the data of staging entry k.
- R5: Writing 0x25 with bit 0 = 1 while idle starts a burst. Bit 0 of 0x25 reads 1 while a burst is running.
- R6: The byte count sent is the smaller of C+1 and 256-A. No transaction uses an address that has wrapped past 0xFF.
- R7: While link_valid is high and link_ack is low, link_reg_addr and link_data hold steady. A byte counts as sent only on a cycle with both high.
- R8: In the cycle after the last byte is acknowledged, bit 7 of register 0x02 reads 1 and irq_n is low.
- R9: Any accepted host write to 0x02 clears bit 7, and irq_n is high from the next cycle.
- R10: Register 0x24 bits [1:0] select the mode. With 00 (hold), hb_ready is low from the cycle after an accepted start until the burst ends. With any other value, hb_ready stays high.
- R11: A start write made during a burst is ignored. So is a rewrite of 0x23 during a burst: the running burst keeps its address, data, count and ID.
- R12: A host write presented while hb_ready is low is ignored.
- R13: After reset, irq_n and hb_ready are high, link_valid is low, and registers 0x02 and 0x25 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hb_addr | input | 8 | Host register address |
| hb_wdata | input | 8 | Host write data |
| hb_we | input | 1 | Host write strobe |
| hb_rdata | output | 8 | Host read data for hb_addr (combinational) |
| hb_ready | output | 1 | Host bus ready; low while a hold-mode burst runs |
| link_valid | output | 1 | A link transaction is being offered |
| link_dev_id | output | 7 | Target device ID of the transaction |
| link_reg_addr | output | 8 | Remote register address of the transaction |
| link_data | output | 8 | Data byte of the transaction |
| link_ack | input | 1 | Link accepts the offered transaction |
| irq_n | output | 1 | Active-low completion interrupt |

## Verification
A sequencer whose index or latched length is wrong shows up at the link port on the first wrong byte: the address, the data or the number of transactions goes astray, and the scoreboard catches it as soon as that byte is acknowledged. A broken completion flag shows up in irq_n and in status bit 7 one cycle after the last acknowledge, or one cycle after a clear. If the hold flag is wrong, hb_ready is at the wrong level in the very next cycle after start. Stalls on link_ack with a toggling acknowledge expose any address or data that moves while it waits.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  localparam logic [7:0] A_STATUS   = 8'h02;
  localparam logic [7:0] A_BUF_BASE = 8'h10;
  localparam logic [7:0] A_DEV      = 8'h20;
  localparam logic [7:0] A_COUNT    = 8'h21;
  localparam logic [7:0] A_RADDR    = 8'h23;
  localparam logic [7:0] A_MODE     = 8'h24;
  localparam logic [7:0] A_GO       = 8'h25;

  localparam logic [1:0] MODE_HOLD = 2'b00;
  localparam logic [1:0] MODE_FREE = 2'b01;

  // bytes actually sent: requested count, cut so the last address is 0xFF at most
  function automatic logic [8:0] burst_len(input logic [7:0] want, input logic [7:0] base);
    logic [8:0] room;
    room = 9'd256 - {1'b0, base};
    if ({1'b0, want} > room) return room;
    return {1'b0, want};
  endfunction
endpackage

// File: rtl/rwb_regs.sv
module rwb_regs
  import rwb_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int ID_W      = 7,
  parameter logic [ID_W-1:0] DEV_RST = 7'h0B,
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             busy,
  input  logic             done,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rdata,
  output logic [ID_W-1:0]  dev_id,
  output logic [IDX_W-1:0] count,
  output logic [7:0]       base,
  output logic [1:0]       mode,
  output logic [7:0]       buf_byte
);
  logic [7:0] stage [BUF_DEPTH];
  logic       in_buf;
  logic [7:0] buf_off;

  assign buf_off = addr - A_BUF_BASE;
  assign in_buf  = (addr >= A_BUF_BASE) && (buf_off < 8'(BUF_DEPTH));

  for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stage[g] <= '0;
      else if (wr_en && addr == 8'(A_BUF_BASE + g))
        stage[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_id <= DEV_RST;
      count  <= '0;
      base   <= 8'h80;
      mode   <= MODE_HOLD;
    end else if (wr_en) begin
      case (addr)
        A_DEV:   dev_id <= wdata[ID_W-1:0];
        A_COUNT: count  <= wdata[IDX_W-1:0];
        A_RADDR: base   <= wdata;
        A_MODE:  mode   <= wdata[1:0];
        default: ;
      endcase
    end
  end

  assign buf_byte = stage[rd_idx];

  always_comb begin
    rdata = '0;
    if (in_buf) rdata = stage[buf_off[IDX_W-1:0]];
    else begin
      case (addr)
        A_STATUS: rdata = {done, 7'b0};
        A_DEV:    rdata = 8'(dev_id);
        A_COUNT:  rdata = 8'(count);
        A_RADDR:  rdata = base;
        A_MODE:   rdata = {6'b0, mode};
        A_GO:     rdata = {7'b0, busy};
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rwb_seq.sv
module rwb_seq
  import rwb_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int ID_W      = 7,
  localparam int IDX_W    = $clog2(BUF_DEPTH),
  localparam int LEN_W    = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [ID_W-1:0]  dev_id,
  input  logic [IDX_W-1:0] count,
  input  logic [7:0]       base,
  input  logic             link_ack,
  output logic             busy,
  output logic             start_ok,
  output logic             done_evt,
  output logic [IDX_W-1:0] idx,
  output logic [ID_W-1:0]  dev_lat,
  output logic [7:0]       cur_addr
);
  logic [LEN_W-1:0] len_lat;
  logic [7:0]       base_lat;
  logic             last;
  logic             xfer;

  assign start_ok = start_req && !busy;
  assign xfer     = busy && link_ack;
  assign last     = ({1'b0, idx} == len_lat - 1'b1);
  assign done_evt = xfer && last;
  assign cur_addr = base_lat + 8'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      len_lat  <= '0;
      base_lat <= '0;
      dev_lat  <= '0;
    end else if (start_ok) begin
      busy     <= 1'b1;
      idx      <= '0;
      len_lat  <= LEN_W'(burst_len(8'(count) + 8'd1, base));
      base_lat <= base;
      dev_lat  <= dev_id;
    end else if (done_evt) begin
      busy <= 1'b0;
    end else if (xfer) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/remote_wr_bridge.sv
module remote_wr_bridge
  import rwb_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int ID_W      = 7,
  parameter logic [ID_W-1:0] DEV_RST = 7'h0B,
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      hb_addr,
  input  logic [7:0]      hb_wdata,
  input  logic            hb_we,
  output logic [7:0]      hb_rdata,
  output logic            hb_ready,
  output logic            link_valid,
  output logic [ID_W-1:0] link_dev_id,
  output logic [7:0]      link_reg_addr,
  output logic [7:0]      link_data,
  input  logic            link_ack,
  output logic            irq_n
);
  logic             wr_en;
  logic             start_req;
  logic             start_ok;
  logic             status_clr;
  logic             done_evt;
  logic             busy;
  logic             done;
  logic             hold;
  logic [IDX_W-1:0] idx;
  logic [ID_W-1:0]  dev_id;
  logic [IDX_W-1:0] count;
  logic [7:0]       base;
  logic [1:0]       mode;

  assign hb_ready   = !(busy && hold);
  assign wr_en      = hb_we && hb_ready;
  assign start_req  = wr_en && (hb_addr == A_GO) && hb_wdata[0];
  assign status_clr = wr_en && (hb_addr == A_STATUS);

  rwb_regs #(.BUF_DEPTH(BUF_DEPTH), .ID_W(ID_W), .DEV_RST(DEV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(hb_addr), .wdata(hb_wdata),
    .busy(busy), .done(done), .rd_idx(idx), .rdata(hb_rdata), .dev_id(dev_id),
    .count(count), .base(base), .mode(mode), .buf_byte(link_data)
  );

  rwb_seq #(.BUF_DEPTH(BUF_DEPTH), .ID_W(ID_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .dev_id(dev_id),
    .count(count), .base(base), .link_ack(link_ack), .busy(busy),
    .start_ok(start_ok), .done_evt(done_evt), .idx(idx),
    .dev_lat(link_dev_id), .cur_addr(link_reg_addr)
  );

  assign link_valid = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      hold <= 1'b0;
    end else begin
      if (done_evt)        done <= 1'b1;
      else if (status_clr) done <= 1'b0;
      if (start_ok)        hold <= (mode == MODE_HOLD);
      else if (done_evt)   hold <= 1'b0;
    end
  end

  assign irq_n = !done;
endmodule

// File: rtl/rwb_chk.sv
module rwb_chk #(parameter int ID_W = 7) (
  input logic            clk,
  input logic            rst_n,
  input logic            hb_ready,
  input logic            link_valid,
  input logic            link_ack,
  input logic [ID_W-1:0] link_dev_id,
  input logic [7:0]      link_reg_addr,
  input logic [7:0]      link_data,
  input logic            irq_n,
  input logic            done_evt,
  input logic            status_clr,
  input logic            start_req
);
  // R8
  cmpl_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !irq_n);
  // R9
  clr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr && !done_evt |=> irq_n);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid && !link_ack |=> link_valid && $stable(link_reg_addr) && $stable(link_data));
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid && link_ack && !done_evt |=> link_valid && link_reg_addr == $past(link_reg_addr) + 8'd1);
  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid && link_ack && !done_evt |-> link_reg_addr != 8'hFF);
  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_req && link_valid |=> $stable(link_dev_id));
  // R10
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hb_ready |-> link_valid);
endmodule

bind remote_wr_bridge rwb_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hb_ready(hb_ready), .link_valid(link_valid),
  .link_ack(link_ack), .link_dev_id(link_dev_id), .link_reg_addr(link_reg_addr),
  .link_data(link_data), .irq_n(irq_n), .done_evt(done_evt),
  .status_clr(status_clr), .start_req(start_req)
);

// File: tb/remote_wr_bridge_test.sv
module remote_wr_bridge_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] hb_addr = '0, hb_wdata = '0;
  logic       hb_we = 1'b0;
  logic [7:0] hb_rdata;
  logic       hb_ready, link_valid, link_ack = 1'b1, irq_n;
  logic [6:0] link_dev_id;
  logic [7:0] link_reg_addr, link_data;

  int checks = 0, fails = 0;
  logic [7:0]  model_buf [16];
  logic [22:0] exp_q [$];   // {dev, addr, data}
  bit ack_toggle = 1'b0;

  always #5 clk = ~clk;

  remote_wr_bridge uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // acknowledge pattern, changed just after each edge
  always begin
    @(posedge clk); #1;
    link_ack = ack_toggle ? ~link_ack : 1'b1;
  end

  // monitor: compares every acknowledged transaction with the scoreboard
  logic [7:0] held_addr, held_data;
  bit         held = 1'b0;
  always @(negedge clk) begin
    if (held && link_valid) begin
      check("R7 stall addr", link_reg_addr, held_addr);
      check("R7 stall data", link_data, held_data);
    end
    held = 1'b0;
    if (link_valid && !link_ack) begin
      held = 1'b1; held_addr = link_reg_addr; held_data = link_data;
    end
    if (link_valid && link_ack) begin
      if (exp_q.size() == 0) check("R6 extra transaction", {9'b0, link_dev_id, link_reg_addr, link_data}, 32'hFFFF_FFFF);
      else check("R4 transaction", {9'b0, link_dev_id, link_reg_addr, link_data}, {9'b0, exp_q.pop_front()});
    end
  end

  task automatic hwrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); hb_addr = a; hb_wdata = d; hb_we = 1'b1;
    @(posedge clk); #1; hb_we = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); hb_addr = a; #1; d = hb_rdata;
  endtask

  task automatic push_burst(input logic [6:0] dev, input logic [7:0] base, input int cnt);
    int n = cnt + 1;
    if (n > 256 - base) n = 256 - base;
    for (int k = 0; k < n; k++) exp_q.push_back({dev, 8'(base + k), model_buf[k]});
  endtask

  task automatic wait_irq(input string req);
    int t = 0;
    while (irq_n !== 1'b0 && t < 200) begin @(negedge clk); t++; end
    check(req, irq_n, 1'b0);
  endtask

  logic [7:0] rd;

  initial begin
    fork
      begin
        repeat (3) @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check("R13 irq_n", irq_n, 1'b1);
        check("R13 ready", hb_ready, 1'b1);
        check("R13 valid", link_valid, 1'b0);
        hread(8'h02, rd); check("R13 status", rd, 8'h00);
        hread(8'h25, rd); check("R13 busy", rd, 8'h00);
        hread(8'h20, rd); check("R2 reset id", rd, 8'h0B);

        for (int i = 0; i < 16; i++) begin
          model_buf[i] = 8'hA0 + 8'(i * 3);
          hwrite(8'h10 + 8'(i), model_buf[i]);
        end
        hread(8'h10, rd); check("R1 entry0", rd, model_buf[0]);
        hread(8'h1F, rd); check("R1 entry15", rd, model_buf[15]);

        // hold mode, 4 bytes from 0x80
        hwrite(8'h24, 8'h00);
        hwrite(8'h20, 8'h2A);
        hwrite(8'h21, 8'h03);
        hwrite(8'h23, 8'h80);
        push_burst(7'h2A, 8'h80, 3);
        hwrite(8'h25, 8'h01);
        @(negedge clk);
        check("R10 ready low in hold", hb_ready, 1'b0);
        hread(8'h25, rd); check("R5 busy bit", rd, 8'h01);
        hwrite(8'h20, 8'h55);
        wait_irq("R8 irq after hold burst");
        check("R10 ready back", hb_ready, 1'b1);
        hread(8'h02, rd); check("R8 status bit", rd, 8'h80);
        check("R3 all bytes sent", exp_q.size(), 0);
        hread(8'h20, rd); check("R12 write while stalled", rd, 8'h2A);

        hwrite(8'h02, 8'h00);
        @(negedge clk);
        check("R9 irq released", irq_n, 1'b1);
        hread(8'h02, rd); check("R9 status cleared", rd, 8'h00);

        // free mode, truncated burst with stalls
        ack_toggle = 1'b1;
        hwrite(8'h24, 8'h01);
        hwrite(8'h21, 8'h0F);
        hwrite(8'h23, 8'hF8);
        push_burst(7'h2A, 8'hF8, 15);
        hwrite(8'h25, 8'h01);
        @(negedge clk);
        check("R10 ready high in free", hb_ready, 1'b1);
        hwrite(8'h23, 8'h90);
        hwrite(8'h25, 8'h01);
        check("R11 still running", link_valid, 1'b1);
        wait_irq("R8 irq after free burst");
        check("R6 truncated count", exp_q.size(), 0);
        @(negedge clk);
        check("R11 no restart", link_valid, 1'b0);
        hwrite(8'h02, 8'h00);

        // single byte
        ack_toggle = 1'b0;
        hwrite(8'h21, 8'h00);
        hwrite(8'h23, 8'hC0);
        push_burst(7'h2A, 8'hC0, 0);
        hwrite(8'h25, 8'h01);
        wait_irq("R3 single byte done");
        check("R3 single byte count", exp_q.size(), 0);
      end
      begin
        repeat (20000) @(posedge clk);
        check("watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule